// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block sits beside the register file of a 16550-style serial controller. Several interrupt sources arrive at its inputs: line status errors, a receive character timeout, receive data availability, an empty transmit holding register, and modem status changes. The block selects the most urgent source that is enabled and presents it as an 8-bit identification value. It also drives a single interrupt request line. The shifters, the baud generator and the FIFOs live elsewhere and appear here only as status inputs.

The block owns two pieces of state. The first is the 4-bit interrupt enable value. The second is a hidden pending flag for the transmit-empty source. That flag is armed when the holding register drains, or when the enable register is written while the holding register is already empty. It is disarmed by a read of the identification register or by a write to the holding register. The identification value and the request line are registered, so they follow any input change after exactly one clock edge.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, `iir` is 0x01, `irq` is low and `ier_val` is 0x00.
- R2: If `ier_val` bit 2 is set and any of `line_st` bits 4:1 (break, framing, parity, overrun) is set, `iir[3:0]` is 0x6. This source outranks all other sources.
- R3: When `tmo_pend` is high and R2 does not apply, `iir[3:0]` is 0xC. No enable bit gates this source.
- R4: The receive data code 0x4 needs `ier_val` bit 0 and `line_st` bit 0 (data ready). With `fifo_en` high it also needs `rx_count >= rx_trig`. This source ranks below R2 and R3.
- R5: The transmit-empty code 0x2 needs `ier_val` bit 1 and the hidden pending flag. It ranks below R4.
- R6: The pending flag is set by `thr_drained`, or by `ier_wr` while `line_st` bit 5 (holding register empty) is high. It is cleared by `iir_rd` or `thr_wr`. A set in the same cycle as a clear wins.
- R7: The modem status code 0x0 needs `ier_val` bit 3 and any bit of `msr_delta`. It has the lowest priority. With no qualifying source, `iir[3:0]` is 0x1.
- R8: `iir[7:6]` reads 11 when `fifo_en` is high and 00 otherwise. `iir[5:4]` is always 00. `ier_val` holds the last value written through `ier_wdata`, with bits 7:4 reading 0.
- R9: `irq` is high exactly when `iir[3:0]` is not 0x1. Both outputs reflect inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_wr | input | 1 | Write strobe for the interrupt enable register |
| ier_wdata | input | 4 | Enable bits: 0 receive data, 1 transmit empty, 2 line status, 3 modem status |
| iir_rd | input | 1 | Read strobe of the identification register |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| thr_drained | input | 1 | One-cycle pulse when the holding register becomes empty |
| line_st | input | 6 | Line status: 0 data ready, 1 overrun, 2 parity, 3 framing, 4 break, 5 holding empty |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| tmo_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| ier_val | output | 8 | Interrupt enable readback |
| iir | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep walks every combination of the 4 enable bits against seven source conditions. Those conditions are line error, timeout, data ready, FIFO mode, count at or above trigger, modem delta and transmit-pending. Together the enables and conditions give 2048 patterns. The sweep rotates which error bit, which modem delta bit and which trigger level is used. This separates a wrong priority order from a wrong enable gating. It also separates the FIFO-gated receive condition from the plain one. Directed cases then exercise the pending flag on its own. They cover set by drain and by enable write, clear by identification read and by holding write, and the set-wins collision. A final case checks that the outputs move exactly one edge after an input changes.

// File: rtl/uart_irq_pkg.sv
// Shared identification codes for the UART interrupt priority block.
package uart_irq_pkg;
    typedef enum logic [3:0] {
        ID_MODEM = 4'h0,
        ID_NONE  = 4'h1,
        ID_THRE  = 4'h2,
        ID_RXDAT = 4'h4,
        ID_LINE  = 4'h6,
        ID_TMO   = 4'hC
    } irq_id_e;
endpackage

// File: rtl/uart_thre_pend.sv
// Hidden transmit-empty pending flag.
// Assumes strobes are single-cycle; a set in the same cycle as a clear wins.
// Exposes the next-state value so that downstream logic sees it without delay.
module uart_thre_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pend_d,
    output logic pend_q
);
    // Next-state: set has precedence over clear.
    always_comb begin
        if (set_evt)      pend_d = 1'b1;
        else if (clr_evt) pend_d = 1'b0;
        else              pend_d = pend_q;
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/uart_irq_select.sv
// Combinational fixed-priority selector for the UART interrupt sources.
// Assumes all inputs are already qualified for the current cycle.
module uart_irq_select #(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ier,
    input  logic             err_any,
    input  logic             tmo,
    input  logic             data_rdy,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             thre_pend,
    input  logic             msr_any,
    output uart_irq_pkg::irq_id_e id
);
    import uart_irq_pkg::*;

    logic rx_ok;

    // Receive condition: FIFO mode also needs the trigger level reached.
    always_comb rx_ok = data_rdy && (!fifo_en || (rx_count >= rx_trig));

    // Priority chain, highest first.
    always_comb begin
        if (ier[2] && err_any)       id = ID_LINE;
        else if (tmo)                id = ID_TMO;
        else if (ier[0] && rx_ok)    id = ID_RXDAT;
        else if (ier[1] && thre_pend) id = ID_THRE;
        else if (ier[3] && msr_any)  id = ID_MODEM;
        else                         id = ID_NONE;
    end
endmodule

// File: rtl/uart_irq_prio.sv
// UART interrupt identification: holds the enable register and the hidden
// transmit-empty flag, runs the priority selector, and registers the
// identification value and request line (one edge of latency from inputs).
// Assumes strobes are single-cycle pulses in the clk domain.
module uart_irq_prio #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [3:0]       ier_wdata,
    input  logic             iir_rd,
    input  logic             thr_wr,
    input  logic             thr_drained,
    input  logic [5:0]       line_st,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             tmo_pend,
    input  logic [3:0]       msr_delta,
    output logic [7:0]       ier_val,
    output logic [7:0]       iir,
    output logic             irq
);
    import uart_irq_pkg::*;

    logic [3:0] ier_q, ier_d;
    logic       pend_d, pend_q;
    irq_id_e    sel_id;
    logic [7:0] iir_q;
    logic       irq_q;

    // Enable register next value, so a write takes effect on the same edge.
    always_comb ier_d = ier_wr ? ier_wdata : ier_q;

    // Enable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ier_q <= 4'h0;
        else        ier_q <= ier_d;
    end

    uart_thre_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (thr_drained || (ier_wr && line_st[5])),
        .clr_evt (iir_rd || thr_wr),
        .pend_d  (pend_d),
        .pend_q  (pend_q)
    );

    uart_irq_select #(.CNT_W(CNT_W)) u_sel (
        .ier       (ier_d),
        .err_any   (|line_st[4:1]),
        .tmo       (tmo_pend),
        .data_rdy  (line_st[0]),
        .fifo_en   (fifo_en),
        .rx_count  (rx_count),
        .rx_trig   (rx_trig),
        .thre_pend (pend_d),
        .msr_any   (|msr_delta),
        .id        (sel_id)
    );

    // Output registers: identification value and request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iir_q <= {4'h0, ID_NONE};
            irq_q <= 1'b0;
        end else begin
            iir_q <= {{2{fifo_en}}, 2'b00, sel_id};
            irq_q <= (sel_id != ID_NONE);
        end
    end

    assign ier_val = {4'h0, ier_q};
    assign iir     = iir_q;
    assign irq     = irq_q;

    assert_line_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ier_q[2] && $past(|line_st[4:1])) |-> iir_q[3:0] == 4'h6);

    assert_tmo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !(ier_q[2] && $past(|line_st[4:1])) && $past(tmo_pend))
        |-> iir_q[3:0] == 4'hC);

    assert_rd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(iir_rd) && !$past(ier_wr) && !$past(thr_drained))
        |-> iir_q[3:0] != 4'h2);

    assert_fifo_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (iir_q[7:6] == {2{$past(fifo_en)}} && iir_q[5:4] == 2'b00));

    assert_irq_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (iir_q[3:0] != 4'h1));

    assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iir_q[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});
endmodule

// File: tb/uart_irq_prio_test.sv
module uart_irq_prio_test;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ier_wr = 0, iir_rd = 0, thr_wr = 0, thr_drained = 0;
    logic [3:0] ier_wdata = 0;
    logic [5:0] line_st = 0;
    logic fifo_en = 0, tmo_pend = 0;
    logic [CNT_W-1:0] rx_count = 0, rx_trig = 0;
    logic [3:0] msr_delta = 0;
    logic [7:0] ier_val, iir;
    logic irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_irq_prio #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .thr_drained(thr_drained),
        .line_st(line_st), .fifo_en(fifo_en), .rx_count(rx_count),
        .rx_trig(rx_trig), .tmo_pend(tmo_pend), .msr_delta(msr_delta),
        .ier_val(ier_val), .iir(iir), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [3:0] en, input bit err, input bit to,
                                         input bit dr, input bit fe, input bit ge,
                                         input bit pend, input bit ms);
        logic [3:0] c;
        if (en[2] && err) c = 4'h6;
        else if (to) c = 4'hC;
        else if (en[0] && dr && (!fe || ge)) c = 4'h4;
        else if (en[1] && pend) c = 4'h2;
        else if (en[3] && ms) c = 4'h0;
        else c = 4'h1;
        return {fe, fe, 2'b00, c};
    endfunction

    function automatic logic [CNT_W-1:0] trig_of(input int k);
        case (k % 4)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 iir", iir, 8'h01);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 ier", ier_val, 8'h00);

        // Sweep R2 R3 R4 R5 R7 R8 R9
        for (int c = 0; c < 2048; c++) begin
            logic [3:0] en;
            bit err, to, dr, fe, ge, ms, pend;
            logic [CNT_W-1:0] tr;
            logic [7:0] e;
            en = c[3:0]; err = c[4]; to = c[5]; dr = c[6]; fe = c[7];
            ge = c[8]; ms = c[9]; pend = c[10];
            tr = trig_of(c >> 2);
            line_st = {1'b0, err ? 4'(1 << (c % 4)) : 4'h0, dr};
            tmo_pend = to; fifo_en = fe; rx_trig = tr;
            rx_count = ge ? tr + CNT_W'(c % 3) : tr - 1;
            msr_delta = ms ? 4'(1 << ((c >> 1) % 4)) : 4'h0;
            ier_wr = 1; ier_wdata = en;
            thr_drained = pend; iir_rd = !pend;
            @(posedge clk); @(negedge clk);
            e = model(en, err, to, dr, fe, ge, pend, ms);
            chk("R2-R7 sweep iir", iir, e);
            chk("R9 sweep irq", {7'b0, irq}, {7'b0, e[3:0] != 4'h1});
            chk("R8 sweep ier", ier_val, {4'h0, en});
            ier_wr = 0; thr_drained = 0; iir_rd = 0;
        end

        // R6 directed: quiet sources, transmit-empty only
        line_st = 6'b100000; tmo_pend = 0; msr_delta = 0; fifo_en = 0;
        ier_wr = 1; ier_wdata = 4'h2;
        @(posedge clk); @(negedge clk); ier_wr = 0;
        chk("R6 ier write while empty sets", iir, 8'h02);
        iir_rd = 1; @(posedge clk); @(negedge clk); iir_rd = 0;
        chk("R6 iir read clears", iir, 8'h01);
        thr_drained = 1; @(posedge clk); @(negedge clk); thr_drained = 0;
        chk("R6 drain sets", iir, 8'h02);
        thr_wr = 1; @(posedge clk); @(negedge clk); thr_wr = 0;
        chk("R6 holding write clears", iir, 8'h01);
        thr_drained = 1; iir_rd = 1; @(posedge clk); @(negedge clk);
        thr_drained = 0; iir_rd = 0;
        chk("R6 set wins over clear", iir, 8'h02);
        line_st = 6'b000000; iir_rd = 1; @(posedge clk); @(negedge clk); iir_rd = 0;
        ier_wr = 1; ier_wdata = 4'h2; @(posedge clk); @(negedge clk); ier_wr = 0;
        chk("R6 ier write while not empty no set", iir, 8'h01);

        // R9 latency: one edge after input change
        ier_wr = 1; ier_wdata = 4'h8; @(posedge clk); @(negedge clk); ier_wr = 0;
        msr_delta = 4'h4;
        chk("R9 before edge", iir, 8'h01);
        @(posedge clk); @(negedge clk);
        chk("R9 after one edge iir", iir, 8'h00);
        chk("R9 after one edge irq", {7'b0, irq}, 8'h01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule